// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen 32-bit general registers of a processor core whose registers are banked by operating mode. The core's current 5-bit mode code selects which physical copy each architectural register index refers to. One combinational read port and one clocked write port both follow the selected mode's view of the register set.

Each port also has its own force-user flag. When that flag is set, the access reaches the user-mode copy of a banked register from any privileged mode. Block-transfer instructions use this path to save or restore user state while they run in a privileged mode.

Register indices 0 to 7 and the program counter (index 15) are stored once. Indices 8 to 12 have a second copy for the fast-interrupt mode. Indices 13 and 14 have one copy for the shared user/system view and one copy for each of the five exception modes. In total there are 31 physical words.

Top module: `banked_regfile`

## Requirements
- R1: Register indices 0 to 7 are never banked. A value written to one of them in any mode is read back at that index in every mode.
- R2: Indices 8 to 12 have a separate copy only in fast-interrupt mode (code 0x11). Every other mode reads and writes the user copy of these indices.
- R3: Indices 13 and 14 have a separate copy for each of the modes fast-interrupt (0x11), interrupt (0x12), supervisor (0x13), abort (0x17) and undefined (0x1B). User (0x10) and system (0x1F) share one copy.
- R4: Index 15 is one register shared by every mode.
- R5: In fast-interrupt mode, an access with the port's force-user flag set reaches the user copy of indices 8 to 12 and leaves the fast-interrupt copy untouched.
- R6: In a mode other than user or system, an access with the force-user flag set reaches the user copy of indices 13 and 14 and leaves the mode's own copy untouched. In user or system mode, the flag changes nothing.
- R7: Mode codes other than the seven listed in R2 and R3 drive mode_err_o high and are handled exactly as user mode. A listed code drives mode_err_o low.
- R8: The read data is a combinational function of the current inputs and the stored state. A write lands on the rising clock edge only when wr_en_i is high. A read of the word being written in the same cycle returns the old value.
- R9: An active-high synchronous reset clears every physical copy to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 5 | Current processor mode code |
| mode_err_o | output | 1 | High when mode_i is not a known code |
| rd_idx_i | input | 4 | Read register index |
| rd_force_user_i | input | 1 | Read reaches the user copy |
| rd_data_o | output | 32 | Read data |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Write register index |
| wr_force_user_i | input | 1 | Write reaches the user copy |
| wr_data_i | input | 32 | Write data |

## Verification
The bench fills each bank with a distinct value and reads it back from every mode that should or should not see it. A wrong bank decode shows up as a value leaking into the wrong mode, or as a privileged mode seeing the user word. Forced writes in fast-interrupt and abort mode are checked both ways: the user copy must change and the mode's own copy must keep its old value. A design that ignores the flag, or that writes both copies, fails one of these two reads. Unknown mode codes must raise the error output and alias the user bank. A read and write to the same index in one cycle must return the old value before the edge, which catches a design that forwards write data to the read port.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int MODE_W    = 5;
    localparam int IDX_W     = 4;
    localparam int NUM_LOW   = 8;
    localparam int NUM_HI    = 5;
    localparam int NUM_BANKS = 6;
    localparam int HI_USR_BASE = NUM_LOW;
    localparam int HI_FIQ_BASE = HI_USR_BASE + NUM_HI;
    localparam int SPLR_BASE   = HI_FIQ_BASE + NUM_HI;
    localparam int PC_SLOT     = SPLR_BASE + 2 * NUM_BANKS;
    localparam int NUM_SLOTS   = PC_SLOT + 1;
    localparam int SLOT_W      = $clog2(NUM_SLOTS);

    localparam logic [MODE_W-1:0] MD_USR = 5'h10;
    localparam logic [MODE_W-1:0] MD_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] MD_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MD_SVC = 5'h13;
    localparam logic [MODE_W-1:0] MD_ABT = 5'h17;
    localparam logic [MODE_W-1:0] MD_UND = 5'h1B;
    localparam logic [MODE_W-1:0] MD_SYS = 5'h1F;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;
endpackage

// File: rtl/rf_mode_decode.sv
module rf_mode_decode
    import rf_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output bank_e             bank_o,
    output logic              err_o
);
    always_comb begin
        err_o  = 1'b0;
        bank_o = BK_USR;
        unique case (mode_i)
            MD_USR, MD_SYS: bank_o = BK_USR;
            MD_FIQ:         bank_o = BK_FIQ;
            MD_IRQ:         bank_o = BK_IRQ;
            MD_SVC:         bank_o = BK_SVC;
            MD_ABT:         bank_o = BK_ABT;
            MD_UND:         bank_o = BK_UND;
            default:        err_o  = 1'b1;
        endcase
    end
endmodule

// File: rtl/rf_bank_map.sv
module rf_bank_map
    import rf_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    input  bank_e             bank_i,
    input  logic              force_user_i,
    output logic [SLOT_W-1:0] slot_o
);
    bank_e eff_bank;
    int    slot_int;

    always_comb begin
        eff_bank = force_user_i ? BK_USR : bank_i;
        if (int'(idx_i) < NUM_LOW) begin
            slot_int = int'(idx_i);
        end else if (int'(idx_i) < NUM_LOW + NUM_HI) begin
            slot_int = (eff_bank == BK_FIQ) ? HI_FIQ_BASE + int'(idx_i) - NUM_LOW
                                             : HI_USR_BASE + int'(idx_i) - NUM_LOW;
        end else if (int'(idx_i) < NUM_LOW + NUM_HI + 2) begin
            slot_int = SPLR_BASE + 2 * int'(eff_bank) + int'(idx_i) - (NUM_LOW + NUM_HI);
        end else begin
            slot_int = PC_SLOT;
        end
        slot_o = SLOT_W'(slot_int);
    end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int DATA_W    = 32,
    parameter int NUM_SLOTS = 31,
    parameter int SLOT_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [SLOT_W-1:0] wa_i,
    input  logic [DATA_W-1:0] wd_i,
    input  logic [SLOT_W-1:0] ra_i,
    output logic [DATA_W-1:0] rd_o
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0][DATA_W-1:0] slot;
    } store_t;

    store_t store_d, store_q;

    always_comb begin
        store_d = store_q;
        if (rst) begin
            store_d = '0;
        end else if (we_i && int'(wa_i) < NUM_SLOTS) begin
            store_d.slot[wa_i] = wd_i;
        end
    end

    always_ff @(posedge clk) begin
        store_q <= store_d;
    end

    always_comb begin
        rd_o = '0;
        if (int'(ra_i) < NUM_SLOTS) rd_o = store_q.slot[ra_i];
    end

    // R8: a write lands at the next edge
    p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
        we_i |=> store_q.slot[$past(wa_i)] == $past(wd_i));

    // R8: no write enable, no change
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(store_q));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_i,
    output logic              mode_err_o,
    input  logic [IDX_W-1:0]  rd_idx_i,
    input  logic              rd_force_user_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic              wr_force_user_i,
    input  logic [DATA_W-1:0] wr_data_i
);
    bank_e             cur_bank;
    logic [SLOT_W-1:0] rd_slot;
    logic [SLOT_W-1:0] wr_slot;

    rf_mode_decode u_dec (
        .mode_i (mode_i),
        .bank_o (cur_bank),
        .err_o  (mode_err_o)
    );

    rf_bank_map u_rmap (
        .idx_i        (rd_idx_i),
        .bank_i       (cur_bank),
        .force_user_i (rd_force_user_i),
        .slot_o       (rd_slot)
    );

    rf_bank_map u_wmap (
        .idx_i        (wr_idx_i),
        .bank_i       (cur_bank),
        .force_user_i (wr_force_user_i),
        .slot_o       (wr_slot)
    );

    rf_storage #(
        .DATA_W    (DATA_W),
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_store (
        .clk  (clk),
        .rst  (rst),
        .we_i (wr_en_i),
        .wa_i (wr_slot),
        .wd_i (wr_data_i),
        .ra_i (rd_slot),
        .rd_o (rd_data_o)
    );

    // R1: unbanked low registers are visible from the next mode
    p_low_shared_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_idx_i < 4'd8) |=>
            ((rd_idx_i == $past(wr_idx_i)) -> (rd_data_o == $past(wr_data_i))));

    // R4: program counter shared by every mode
    p_pc_shared_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_idx_i == 4'd15) |=>
            ((rd_idx_i == 4'd15) -> (rd_data_o == $past(wr_data_i))));

    // R6: a forced write is what user mode sees next
    p_force_user_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_force_user_i) |=>
            ((rd_idx_i == $past(wr_idx_i) && mode_i == MD_USR && !rd_force_user_i)
                -> (rd_data_o == $past(wr_data_i))));
endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
    localparam logic [4:0] USR = 5'h10, FIQ = 5'h11, IRQ = 5'h12, SVC = 5'h13,
                           ABT = 5'h17, UND = 5'h1B, SYS = 5'h1F;
    localparam int NV = 46;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  mode = USR;
    logic        mode_err;
    logic [3:0]  rd_idx = '0;
    logic        rd_force = 1'b0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic        wr_force = 1'b0;
    logic [31:0] wr_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    banked_regfile u_dut (
        .clk             (clk),
        .rst             (rst),
        .mode_i          (mode),
        .mode_err_o      (mode_err),
        .rd_idx_i        (rd_idx),
        .rd_force_user_i (rd_force),
        .rd_data_o       (rd_data),
        .wr_en_i         (wr_en),
        .wr_idx_i        (wr_idx),
        .wr_force_user_i (wr_force),
        .wr_data_i       (wr_data)
    );

    // vector: {req[3:0], is_write, mode[4:0], force, idx[3:0], data[31:0]}
    function automatic logic [46:0] v(int req, bit w, logic [4:0] m, bit f,
                                      int idx, logic [31:0] d);
        return {4'(req), w, m, f, 4'(idx), d};
    endfunction

    localparam logic [46:0] VEC [0:NV-1] = '{
        v(1, 1, USR, 0,  3, 32'hA1), // R1
        v(1, 0, FIQ, 0,  3, 32'hA1), // R1
        v(1, 0, SVC, 0,  3, 32'hA1), // R1
        v(1, 1, UND, 0,  6, 32'hA2), // R1
        v(1, 0, SYS, 0,  6, 32'hA2), // R1
        v(2, 1, USR, 0,  9, 32'hB1), // R2
        v(2, 1, FIQ, 0,  9, 32'hB2), // R2
        v(2, 0, USR, 0,  9, 32'hB1), // R2
        v(2, 0, FIQ, 0,  9, 32'hB2), // R2
        v(2, 0, IRQ, 0,  9, 32'hB1), // R2
        v(2, 1, SVC, 0, 12, 32'hB4), // R2
        v(2, 0, USR, 0, 12, 32'hB4), // R2
        v(2, 0, FIQ, 0, 12, 32'h0),  // R2
        v(5, 0, FIQ, 1,  9, 32'hB1), // R5
        v(5, 1, FIQ, 1, 10, 32'hB3), // R5
        v(5, 0, USR, 0, 10, 32'hB3), // R5
        v(5, 0, FIQ, 0, 10, 32'h0),  // R5
        v(3, 1, USR, 0, 13, 32'hC0), // R3
        v(3, 1, SVC, 0, 13, 32'hC1), // R3
        v(3, 1, IRQ, 0, 13, 32'hC2), // R3
        v(3, 1, ABT, 0, 14, 32'hC3), // R3
        v(3, 1, UND, 0, 14, 32'hC4), // R3
        v(3, 1, FIQ, 0, 13, 32'hC5), // R3
        v(3, 1, SYS, 0, 14, 32'hC7), // R3
        v(3, 0, SYS, 0, 13, 32'hC0), // R3
        v(3, 0, USR, 0, 14, 32'hC7), // R3
        v(3, 0, SVC, 0, 13, 32'hC1), // R3
        v(3, 0, IRQ, 0, 13, 32'hC2), // R3
        v(3, 0, ABT, 0, 14, 32'hC3), // R3
        v(3, 0, UND, 0, 14, 32'hC4), // R3
        v(3, 0, FIQ, 0, 13, 32'hC5), // R3
        v(3, 0, SVC, 0, 14, 32'h0),  // R3
        v(3, 0, ABT, 0, 13, 32'h0),  // R3
        v(6, 0, SVC, 1, 13, 32'hC0), // R6
        v(6, 1, ABT, 1, 14, 32'hC6), // R6
        v(6, 0, USR, 0, 14, 32'hC6), // R6
        v(6, 0, ABT, 0, 14, 32'hC3), // R6
        v(6, 0, SYS, 1, 13, 32'hC0), // R6
        v(6, 0, FIQ, 1, 13, 32'hC0), // R6
        v(4, 1, SVC, 0, 15, 32'hD1), // R4
        v(4, 0, FIQ, 0, 15, 32'hD1), // R4
        v(4, 0, USR, 0, 15, 32'hD1), // R4
        v(7, 1, 5'h05, 0, 13, 32'hE1), // R7
        v(7, 0, USR, 0, 13, 32'hE1),   // R7
        v(7, 0, 5'h1A, 0, 13, 32'hE1), // R7
        v(7, 0, 5'h00, 0, 14, 32'hC6)  // R7
    };

    task automatic check(int req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [46:0] e;
        step(); step();
        rst = 1'b0;
        // R9: reset state, every index in several modes
        for (int i = 0; i < 16; i++) begin
            rd_idx = 4'(i);
            mode = FIQ; #1 check(9, rd_data, 32'h0);
            mode = UND; #1 check(9, rd_data, 32'h0);
        end
        step();
        // table walk
        for (int k = 0; k < NV; k++) begin
            e = VEC[k];
            mode = e[41:37];
            if (e[42]) begin
                wr_en = 1'b1; wr_force = e[36]; wr_idx = e[35:32]; wr_data = e[31:0];
                step();
                wr_en = 1'b0; wr_force = 1'b0;
            end else begin
                rd_force = e[36]; rd_idx = e[35:32];
                #1 check(int'(e[46:43]), rd_data, e[31:0]);
                rd_force = 1'b0;
                step();
            end
        end
        // R7: error flag
        mode = 5'h05; #1 check(7, 32'(mode_err), 32'h1);
        mode = 5'h1C; #1 check(7, 32'(mode_err), 32'h1);
        mode = SVC;   #1 check(7, 32'(mode_err), 32'h0);
        mode = SYS;   #1 check(7, 32'(mode_err), 32'h0);
        mode = FIQ;   #1 check(7, 32'(mode_err), 32'h0);
        step();
        // R8: same-cycle read returns old value, new after edge
        mode = IRQ; rd_idx = 4'd3;
        wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hF1;
        #1 check(8, rd_data, 32'hA1);
        step();
        wr_en = 1'b0;
        #1 check(8, rd_data, 32'hF1);
        // R8: data without enable is ignored
        wr_idx = 4'd3; wr_data = 32'hF2;
        step();
        check(8, rd_data, 32'hF1);
        // R9: reset clears banked copies too
        rst = 1'b1;
        step();
        rst = 1'b0;
        mode = FIQ; rd_idx = 4'd13; #1 check(9, rd_data, 32'h0);
        mode = ABT; rd_idx = 4'd14; #1 check(9, rd_data, 32'h0);
        mode = USR; rd_idx = 4'd9;  #1 check(9, rd_data, 32'h0);
        rd_idx = 4'd15; #1 check(9, rd_data, 32'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule